// File: doc/BRIEF.md
# Floating-Point Compare to Condition Code

This block compares two floating-point operands and stores the one-bit outcome in a chosen condition-code bit of a 32-bit floating-point status register that it owns and exposes. It works on double precision (64-bit) operands, on single precision operands held in the low 32 bits, or on two independent single precision lanes packed into one 64-bit word.

Each compare request names an ordered predicate (equal, less-than, less-or-equal), a condition-code index, the outcome to write when the operands are unordered, and whether the compare is the signaling variant. The signaling variant reports invalid on a quiet NaN and then leaves the condition code alone. The status register is updated on the clock edge that samples the request. A valid strobe marks the cycle that follows.

Top module: `fcmp_cc_unit`

## Requirements
- R1: With `dbl_sel`=1, the 64-bit operands are compared. `pred_sel` 00 selects equal, 01 selects a less than b, 10 selects a less or equal b, and 11 is a predicate that is never true.
- R2: With `dbl_sel`=0 and `pair_sel`=0, only bits 31:0 of each operand take part as single precision values. Bits 63:32 have no effect on the status register.
- R3: A NaN has an all-ones exponent and a non-zero fraction. When either operand is a NaN, the value of `unord_val` is written to the selected condition code. This does not apply when R5 takes the compare.
- R4: +0 and -0 compare equal. Non-NaN values are ordered by sign and magnitude, so a more negative value is less than a less negative one, and infinities sit at the two ends of the order.
- R5: A quiet NaN has the most significant fraction bit set. When `sig_mode`=1 and either operand is a quiet NaN, status bit 16 (invalid cause) and status bit 6 (invalid sticky) are set, and the condition code is not written. A signaling NaN under `sig_mode` follows R3 and raises nothing.
- R6: Condition code 0 is held at status bit 23. Condition code k, for k from 1 to 7, is held at bit 24+k. A compare changes no condition-code bit other than the one or ones it targets.
- R7: With `dbl_sel`=0 and `pair_sel`=1, lane 0 (bits 31:0) writes condition code `cc_idx` and lane 1 (bits 63:32) writes condition code (`cc_idx`+1) mod 8. Each lane applies R3 and R5 on its own, and a lane that raises invalid does not stop the other lane from writing. `dbl_sel`=1 overrides `pair_sel`.
- R8: Every accepted request clears the invalid cause bit 16 before applying its own outcome. The sticky bit 6 stays set until reset.
- R9: Reset clears the status register and `done_valid`. `done_valid` is high exactly in the cycle after a cycle with `req_valid` high. With no request, the status register holds its value.
- R10: Status bits other than 6, 16, 23 and 25 to 31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Compare request |
| op_a | input | 64 | First operand (left side of the predicate) |
| op_b | input | 64 | Second operand |
| dbl_sel | input | 1 | 1: double precision, 0: single precision |
| pair_sel | input | 1 | 1 with dbl_sel=0: two single precision lanes |
| cc_idx | input | 3 | Condition-code index |
| pred_sel | input | 2 | Predicate code (00 eq, 01 lt, 10 le, 11 never) |
| unord_val | input | 1 | Outcome written when the operands are unordered |
| sig_mode | input | 1 | Signaling variant |
| done_valid | output | 1 | High in the cycle after a request |
| status_q | output | 32 | Status register with condition codes and invalid flags |

## Verification
In each precision, a set of values (both zeros, small and large values of both signs, a denormal, both infinities, a quiet NaN and a signaling NaN) is compared pairwise under every predicate, both unordered outcomes and both signaling settings. This separates a sign-magnitude ordering error, a zero-sign error, a mix-up between unordered and invalid handling, and a quiet/signaling mix-up. The condition-code index advances with each compare, so the bit positions and the wrap of the paired lane are covered. The paired sweep places different values in the two lanes so that lane crosstalk shows. Single-mode compares put junk in the upper halves, and idle cycles check that the register does not change.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        PRED_EQ   = 2'b00,
        PRED_LT   = 2'b01,
        PRED_LE   = 2'b10,
        PRED_NONE = 2'b11
    } pred_e;

    localparam int STATUS_W       = 32;
    localparam int CC_CNT         = 8;
    localparam int CC_IDX_W       = $clog2(CC_CNT);
    localparam int INV_CAUSE_BIT  = 16;
    localparam int INV_STICKY_BIT = 6;
    localparam int CC0_BIT        = 23;
    localparam int CCN_BASE       = 24;

    localparam logic [STATUS_W-1:0] LIVE_MASK =
        (32'hFE << CCN_BASE) | (32'h1 << CC0_BIT) |
        (32'h1 << INV_CAUSE_BIT) | (32'h1 << INV_STICKY_BIT);

    typedef struct packed {
        logic [STATUS_W-1:0] status;
        logic                vld;
    } unit_state_t;

    function automatic int cc_pos(input logic [CC_IDX_W-1:0] idx);
        return (idx == '0) ? CC0_BIT : (CCN_BASE + int'(idx));
    endfunction

endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] lhs,
    input  logic [EXP_W+FRAC_W:0] rhs,
    input  pred_e                 pred,
    input  logic                  unord_val,
    input  logic                  sig_mode,
    output logic                  wr_en,
    output logic                  res,
    output logic                  inv
);
    localparam int W   = 1 + EXP_W + FRAC_W;
    localparam int MAG = W - 1;

    logic            l_sgn, r_sgn;
    logic [MAG-1:0]  l_mag, r_mag;
    logic            l_nan, r_nan, l_qnan, r_qnan;
    logic            both_zero, is_eq, is_lt, ordered_res;

    always_comb begin
        l_sgn  = lhs[W-1];
        r_sgn  = rhs[W-1];
        l_mag  = lhs[MAG-1:0];
        r_mag  = rhs[MAG-1:0];
        l_nan  = (&lhs[W-2:FRAC_W]) && (|lhs[FRAC_W-1:0]);
        r_nan  = (&rhs[W-2:FRAC_W]) && (|rhs[FRAC_W-1:0]);
        l_qnan = l_nan && lhs[FRAC_W-1];
        r_qnan = r_nan && rhs[FRAC_W-1];

        both_zero = (l_mag == '0) && (r_mag == '0);
        is_eq     = (lhs == rhs) || both_zero;
        if (both_zero)
            is_lt = 1'b0;
        else if (l_sgn != r_sgn)
            is_lt = l_sgn;
        else if (!l_sgn)
            is_lt = l_mag < r_mag;
        else
            is_lt = l_mag > r_mag;

        unique case (pred)
            PRED_EQ: ordered_res = is_eq;
            PRED_LT: ordered_res = is_lt;
            PRED_LE: ordered_res = is_lt || is_eq;
            default: ordered_res = 1'b0;
        endcase

        inv   = sig_mode && (l_qnan || r_qnan);
        wr_en = !inv;
        res   = (l_nan || r_nan) ? unord_val : ordered_res;
    end

    // R4: equality and strict less-than exclude each other
    always_comb begin
        a_r4_eq_lt_exclusive: assert (!(is_eq && is_lt) || $isunknown(lhs) || $isunknown(rhs));
    end

endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
    import fcmp_pkg::*;
#(
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    parameter int LANES     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic        dbl_sel,
    input  logic        pair_sel,
    input  logic [2:0]  cc_idx,
    input  logic [1:0]  pred_sel,
    input  logic        unord_val,
    input  logic        sig_mode,
    output logic        done_valid,
    output logic [31:0] status_q
);
    localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W;

    pred_e pred;
    assign pred = pred_e'(pred_sel);

    logic [LANES-1:0] sp_we, sp_res, sp_inv;
    logic             dp_we, dp_res, dp_inv;

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_sp_lane
            fcmp_lane #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) lane_i (
                .lhs       (op_a[gl*SP_W +: SP_W]),
                .rhs       (op_b[gl*SP_W +: SP_W]),
                .pred      (pred),
                .unord_val (unord_val),
                .sig_mode  (sig_mode),
                .wr_en     (sp_we[gl]),
                .res       (sp_res[gl]),
                .inv       (sp_inv[gl])
            );
        end
    endgenerate

    fcmp_lane #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) dp_lane_i (
        .lhs       (op_a[DP_W-1:0]),
        .rhs       (op_b[DP_W-1:0]),
        .pred      (pred),
        .unord_val (unord_val),
        .sig_mode  (sig_mode),
        .wr_en     (dp_we),
        .res       (dp_res),
        .inv       (dp_inv)
    );

    unit_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.status[INV_CAUSE_BIT] = 1'b0;
            if (dbl_sel) begin
                if (dp_inv) begin
                    st_d.status[INV_CAUSE_BIT]  = 1'b1;
                    st_d.status[INV_STICKY_BIT] = 1'b1;
                end
                if (dp_we)
                    st_d.status[cc_pos(cc_idx)] = dp_res;
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (l == 0 || pair_sel) begin
                        if (sp_inv[l]) begin
                            st_d.status[INV_CAUSE_BIT]  = 1'b1;
                            st_d.status[INV_STICKY_BIT] = 1'b1;
                        end
                        if (sp_we[l])
                            st_d.status[cc_pos(cc_idx + CC_IDX_W'(l))] = sp_res[l];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign done_valid = st_q.vld;
    assign status_q   = st_q.status;

    // R9: strobe follows a request by one cycle
    a_r9_strobe_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done_valid);
    // R9: no request, no change
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(status_q) && !done_valid));
    // R8: sticky invalid never clears while out of reset
    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[INV_STICKY_BIT] |=> status_q[INV_STICKY_BIT]);
    // R5: a raised cause always comes with the sticky flag
    a_r5_cause_implies_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[INV_CAUSE_BIT] |-> status_q[INV_STICKY_BIT]);
    // R10: unused status bits stay zero
    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~LIVE_MASK) == '0);

endmodule

// File: tb/fcmp_cc_unit_tb_top.sv
module fcmp_cc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        dbl_sel = 1'b0, pair_sel = 1'b0;
    logic [2:0]  cc_idx = '0;
    logic [1:0]  pred_sel = '0;
    logic        unord_val = 1'b0, sig_mode = 1'b0;
    logic        done_valid;
    logic [31:0] status_q;

    int checks = 0;
    int bad = 0;
    logic [31:0] model;
    logic [2:0]  cc_run = '0;
    logic [63:0] dvals [12];
    logic [31:0] svals [12];

    always #2 clk = ~clk;

    fcmp_cc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_a(op_a), .op_b(op_b),
        .dbl_sel(dbl_sel), .pair_sel(pair_sel), .cc_idx(cc_idx), .pred_sel(pred_sel),
        .unord_val(unord_val), .sig_mode(sig_mode), .done_valid(done_valid),
        .status_q(status_q)
    );

    function automatic int pos_of(input logic [2:0] k);
        return (k == 3'd0) ? 23 : 24 + int'(k);
    endfunction

    // returns {write, result, invalid} from value arithmetic
    function automatic logic [2:0] ref_cmp(input logic [63:0] a, input logic [63:0] b,
                                           input bit dbl, input logic [1:0] p,
                                           input logic uv, input logic sg);
        longint ka, kb;
        bit an, bn, aq, bq, r;
        if (dbl) begin
            an = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            bn = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            aq = an && a[51];
            bq = bn && b[51];
            ka = longint'({1'b0, a[62:0]});
            kb = longint'({1'b0, b[62:0]});
            if (a[63]) ka = -ka;
            if (b[63]) kb = -kb;
        end else begin
            an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
            aq = an && a[22];
            bq = bn && b[22];
            ka = longint'(a[30:0]);
            kb = longint'(b[30:0]);
            if (a[31]) ka = -ka;
            if (b[31]) kb = -kb;
        end
        if (sg && (aq || bq)) return 3'b001;
        if (an || bn) r = uv;
        else case (p)
            2'b00: r = (ka == kb);
            2'b01: r = (ka < kb);
            2'b10: r = (ka <= kb);
            default: r = 1'b0;
        endcase
        return {1'b1, r, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic run_cmp(input string tag, input logic [63:0] a, input logic [63:0] b,
                           input bit dbl, input bit pr, input logic [1:0] p,
                           input logic uv, input logic sg);
        logic [2:0] r0, r1;
        op_a = a; op_b = b; dbl_sel = dbl; pair_sel = pr; pred_sel = p;
        unord_val = uv; sig_mode = sg; cc_idx = cc_run; req_valid = 1'b1;
        model[16] = 1'b0;
        r0 = ref_cmp(a, b, dbl, p, uv, sg);
        if (r0[0]) begin model[16] = 1'b1; model[6] = 1'b1; end
        if (r0[2]) model[pos_of(cc_run)] = r0[1];
        if (!dbl && pr) begin
            r1 = ref_cmp({32'h0, a[63:32]}, {32'h0, b[63:32]}, 1'b0, p, uv, sg);
            if (r1[0]) begin model[16] = 1'b1; model[6] = 1'b1; end
            if (r1[2]) model[pos_of(cc_run + 3'd1)] = r1[1];
        end
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " strobe"}, {31'h0, done_valid}, 32'h1);
        check(tag, status_q, model);
        cc_run = cc_run + 3'd1;
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        string tg;
        logic [2:0] rr;
        svals = '{32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
                  32'h4000_0000, 32'hC000_0000, 32'h3FC0_0000, 32'h0000_0001,
                  32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 32'h7F80_0001};
        dvals = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                  64'hBFF0_0000_0000_0000, 64'h4000_0000_0000_0000,
                  64'hC000_0000_0000_0000, 64'h3FF8_0000_0000_0000, 64'h1,
                  64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
                  64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001};
        model = '0;
        repeat (3) @(negedge clk);
        check("R9 reset status", status_q, 32'h0);
        check("R9 reset strobe", {31'h0, done_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: every condition-code position, writing a true equal
        for (int k = 0; k < 8; k++)
            run_cmp("R6 cc position", 64'h0, 64'h0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);

        // R1 R3 R4 R5: double sweep
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int p = 0; p < 4; p++)
                    for (int m = 0; m < 4; m++) begin
                        rr = ref_cmp(dvals[i], dvals[j], 1'b1, 2'(p), m[0], m[1]);
                        tg = rr[0] ? "R5 dbl invalid" : (i >= 10 || j >= 10) ? "R3 dbl unordered"
                           : (i < 2 && j < 2) ? "R4 dbl zeros" : "R1 dbl ordered";
                        run_cmp(tg, dvals[i], dvals[j], 1'b1, m[0], 2'(p), m[0], m[1]);
                    end

        // R2: single sweep with junk in upper halves
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int p = 0; p < 4; p++)
                    for (int m = 0; m < 4; m++) begin
                        rr = ref_cmp({32'h0, svals[i]}, {32'h0, svals[j]}, 1'b0, 2'(p), m[0], m[1]);
                        tg = rr[0] ? "R5 sgl invalid" : (i >= 10 || j >= 10) ? "R3 sgl unordered"
                           : (i < 2 && j < 2) ? "R4 sgl zeros" : "R2 sgl ordered";
                        run_cmp(tg, {svals[(i + 3) % 12], svals[i]}, {svals[(j + 10) % 12], svals[j]},
                                1'b0, 1'b0, 2'(p), m[0], m[1]);
                    end

        // R7: paired lanes with different contents
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int p = 0; p < 4; p++)
                    for (int s = 0; s < 2; s++)
                        run_cmp("R7 paired", {svals[(i + 5) % 12], svals[i]},
                                {svals[(j + 7) % 12], svals[j]}, 1'b0, 1'b1, 2'(p), i[0], s[0]);

        // R8: a clean compare clears the cause, sticky remains
        run_cmp("R5 raise", 64'h7FF8_0000_0000_0000, 64'h0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1);
        run_cmp("R8 cause clear", 64'h0, 64'h0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
        check("R8 sticky kept", {31'h0, status_q[6]}, 32'h1);

        // R9: idle cycles hold
        repeat (3) @(negedge clk);
        check("R9 idle status", status_q, model);
        check("R9 idle strobe", {31'h0, done_valid}, 32'h0);
        check("R10 unused bits", status_q & ~32'hFE81_0040, 32'h0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule